// File: doc/BRIEF.md
# ADC Reference Calibration Loop

This block keeps a pair of coarse receive converters working at the right scale. It watches the 3-bit in-phase and quadrature sample codes. On each sample it decides whether either channel hit an extreme code, and adds a programmed signed step to a wide accumulator: the positive step for a saturated sample and the negative step for any other. In balance, the fraction of saturated samples settles where p·pos + (1−p)·neg = 0. With steps of +2 and −1 that fraction is one third.

Only the most significant bits of the accumulator reach the reference DAC control word, which keeps the loop gain low. The control word is refreshed only when a slow update strobe fires, about once per millisecond in a typical system. A 2-bit mode input has three settings. The loop can be switched off, which holds it at mid scale and preloads it so that a later enable settles quickly. It can adapt only while the demodulator reports tracking. Or it can adapt whenever the receiver is enabled.

Top module: `adc_ref_cal`

## Requirements
- R1: While `rst_n` is low, the accumulator is loaded with mid scale (only its top bit set, 0x800000 at the default width) and `cal_dac` becomes mid scale (only its top bit set, 16 for 5 bits).
- R2: A sample counts as saturated when `i_code` or `q_code` equals positive full scale 3'b011 or negative full scale 3'b100, the codes being two's complement. On an adapting cycle with `sample_valid` high, the accumulator adds `step_pos` for a saturated sample and `step_neg` otherwise. Both steps are 8-bit two's complement values, sign-extended to the accumulator width.
- R3: The accumulator clamps at all-ones and at zero instead of wrapping.
- R4: `cal_dac` changes only on a cycle where `update_tick` is high and the mode is not off. It then takes the top OUT_W bits of the accumulator value held before that cycle's update. Otherwise `cal_dac` holds.
- R5: With `cal_mode` 2'b00 or 2'b01 (off), the accumulator is reloaded with mid scale on every cycle and `cal_dac` reads mid scale from the next cycle on, whatever the other inputs are.
- R6: With `cal_mode` 2'b10, the accumulator changes only when both `tracking` and `rx_enable` are high.
- R7: With `cal_mode` 2'b11, the accumulator changes whenever `rx_enable` is high, whatever `tracking` is, and holds when `rx_enable` is low.
- R8: When `sample_valid` is low, the accumulator holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | A new I/Q sample pair is present |
| i_code | input | 3 | In-phase converter code, two's complement |
| q_code | input | 3 | Quadrature converter code, two's complement |
| rx_enable | input | 1 | Receiver enabled |
| tracking | input | 1 | Demodulator is tracking a signal |
| cal_mode | input | 2 | 0x off, 10 adapt while tracking, 11 adapt while receiving |
| step_pos | input | 8 | Signed step added for a saturated sample |
| step_neg | input | 8 | Signed step added for a non-saturated sample |
| update_tick | input | 1 | Slow strobe that refreshes the DAC word |
| cal_dac | output | 5 | Reference DAC control word |

## Verification
The accumulator is internal and shows only through `cal_dac`. A wrong step, a wrong saturation decision or a gating fault stays hidden until the next `update_tick`, and even then it shows only once the error has carried across a top-bit boundary. The bench therefore uses short tick spacings and large steps that drive the loop into both clamps within a few hundred cycles. There the wrapping and clamping faults become visible at once as a jump between 0 and all-ones. Mode and gating faults appear as a DAC word that drifts where the reference model holds, within one tick period.

// File: rtl/adc_ref_cal.sv
module adc_ref_cal #(
  parameter int SMP_W  = 3,
  parameter int ACC_W  = 24,
  parameter int OUT_W  = 5,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [SMP_W-1:0]  i_code,
  input  logic [SMP_W-1:0]  q_code,
  input  logic              rx_enable,
  input  logic              tracking,
  input  logic [1:0]        cal_mode,
  input  logic [STEP_W-1:0] step_pos,
  input  logic [STEP_W-1:0] step_neg,
  input  logic              update_tick,
  output logic [OUT_W-1:0]  cal_dac
);
  localparam logic [SMP_W-1:0] FS_POS  = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] FS_NEG  = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_MID = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] OUT_MID = {1'b1, {(OUT_W-1){1'b0}}};
  localparam int               EXT_W   = ACC_W + 2 - STEP_W;

  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        acc_next;
  logic signed [ACC_W+1:0] step_x;
  logic signed [ACC_W+1:0] sum;
  logic [STEP_W-1:0]       step;
  logic                    hit;
  logic                    cal_off;
  logic                    adapt;

  assign hit = (i_code == FS_POS) || (i_code == FS_NEG) ||
               (q_code == FS_POS) || (q_code == FS_NEG);
  assign step    = hit ? step_pos : step_neg;
  assign step_x  = {{EXT_W{step[STEP_W-1]}}, step};
  assign sum     = $signed({2'b00, acc}) + step_x;
  assign acc_next = sum[ACC_W+1] ? '0 : (sum[ACC_W] ? '1 : sum[ACC_W-1:0]);

  assign cal_off = !cal_mode[1];
  assign adapt   = rx_enable && (cal_mode[0] || tracking);

  always_ff @(posedge clk) begin
    if (!rst_n || cal_off) begin
      acc     <= ACC_MID;
      cal_dac <= OUT_MID;
    end else begin
      if (update_tick)
        cal_dac <= acc[ACC_W-1 -: OUT_W];
      if (adapt && sample_valid)
        acc <= acc_next;
    end
  end
endmodule

// File: rtl/adc_ref_cal_chk.sv
module adc_ref_cal_chk #(
  parameter int ACC_W  = 24,
  parameter int OUT_W  = 5,
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              rx_enable,
  input logic              tracking,
  input logic [1:0]        cal_mode,
  input logic [STEP_W-1:0] step_pos,
  input logic [STEP_W-1:0] step_neg,
  input logic              update_tick,
  input logic [ACC_W-1:0]  acc,
  input logic [OUT_W-1:0]  cal_dac
);
  localparam logic [ACC_W-1:0] ACC_MID = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] OUT_MID = {1'b1, {(OUT_W-1){1'b0}}};

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode[1] && acc == '1 && !step_pos[STEP_W-1] && !step_neg[STEP_W-1]) |=> acc == '1);

  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode[1] && !update_tick) |=> $stable(cal_dac));

  p_off_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode[1] |=> (cal_dac == OUT_MID && acc == ACC_MID));

  p_track_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode == 2'b10 && !tracking) |=> $stable(acc));

  p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode[1] && !rx_enable) |=> $stable(acc));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode[1] && !sample_valid) |=> $stable(acc));
endmodule

bind adc_ref_cal adc_ref_cal_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .rx_enable(rx_enable),
  .tracking(tracking), .cal_mode(cal_mode), .step_pos(step_pos), .step_neg(step_neg),
  .update_tick(update_tick), .acc(acc), .cal_dac(cal_dac)
);

// File: tb/adc_ref_cal_tb.sv
module adc_ref_cal_tb;
  localparam int PERIOD = 10;
  localparam int ACC_W  = 14;
  localparam int OUT_W  = 5;
  localparam int SHIFT  = ACC_W - OUT_W;
  localparam int AMAX   = (1 << ACC_W) - 1;
  localparam int AMID   = 1 << (ACC_W - 1);
  localparam int DMID   = 1 << (OUT_W - 1);

  logic clk = 0, rst_n = 0, sample_valid = 0, rx_enable = 0, tracking = 0, update_tick = 0;
  logic [2:0] i_code = 0, q_code = 0;
  logic [1:0] cal_mode = 2'b00;
  logic [7:0] step_pos = 8'd2, step_neg = 8'hFF;
  logic [OUT_W-1:0] cal_dac;

  int checks = 0, errors = 0;
  int m_acc = AMID, m_dac = DMID;
  int sat_pct = 33, tick_every = 16, valid_pct = 100;
  bit compare_on = 0, done = 0;
  string tag = "R1";

  adc_ref_cal #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .i_code(i_code), .q_code(q_code),
    .rx_enable(rx_enable), .tracking(tracking), .cal_mode(cal_mode), .step_pos(step_pos),
    .step_neg(step_neg), .update_tick(update_tick), .cal_dac(cal_dac));

  always #(PERIOD/2) clk = ~clk;

  function automatic bit is_fs(logic [2:0] c);
    return c == 3'b011 || c == 3'b100;
  endfunction

  function automatic int sx8(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !cal_mode[1]) begin
      m_acc = AMID;
      m_dac = DMID;
    end else begin
      if (update_tick) m_dac = m_acc >> SHIFT;
      if (sample_valid && rx_enable && (cal_mode[0] || tracking)) begin
        m_acc = m_acc + ((is_fs(i_code) || is_fs(q_code)) ? sx8(step_pos) : sx8(step_neg));
        if (m_acc < 0) m_acc = 0;
        if (m_acc > AMAX) m_acc = AMAX;
      end
    end
  end

  task automatic check(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (compare_on) check(tag, int'(cal_dac), m_dac);

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sample_valid = ($urandom % 100) < valid_pct;
      if (($urandom % 100) < sat_pct) begin
        i_code = ($urandom % 2) ? 3'b011 : 3'b100;
        q_code = 3'd1;
        if ($urandom % 2) begin q_code = i_code; i_code = 3'd6; end
      end else begin
        i_code = 3'(($urandom % 3) + (($urandom % 2) ? 0 : 5));
        q_code = 3'(($urandom % 3) + (($urandom % 2) ? 0 : 5));
      end
      update_tick = (k % tick_every) == (tick_every - 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset dac", int'(cal_dac), DMID);
    @(negedge clk);
    rst_n = 1; compare_on = 1;
    cal_mode = 2'b11; rx_enable = 1;

    tag = "R2"; sat_pct = 33; run(400);
    sat_pct = 70; run(300);
    sat_pct = 5; step_pos = 8'd5; step_neg = 8'hFD; run(300);

    tag = "R3"; step_pos = 8'd127; sat_pct = 100; tick_every = 8; run(200);
    run(1); @(negedge clk);
    check("R3 clamp high", int'(cal_dac), (1 << OUT_W) - 1);
    step_neg = 8'h80; sat_pct = 0; run(300);
    run(1); @(negedge clk);
    check("R3 clamp low", int'(cal_dac), 0);

    tag = "R4"; step_pos = 8'd60; step_neg = 8'hC4; sat_pct = 50; tick_every = 37; run(300);
    tick_every = 1; run(60);

    tag = "R6"; cal_mode = 2'b10; tracking = 0; tick_every = 5; sat_pct = 100; run(100);
    tracking = 1; rx_enable = 0; run(60);
    rx_enable = 1; run(150);

    tag = "R7"; cal_mode = 2'b11; tracking = 0; rx_enable = 0; sat_pct = 0; run(80);
    rx_enable = 1; run(120);

    tag = "R8"; valid_pct = 0; sat_pct = 100; run(80);
    valid_pct = 60; step_pos = 8'd2; step_neg = 8'hFF; sat_pct = 33; run(200);

    tag = "R5"; cal_mode = 2'b00; run(40);
    check("R5 off 00 dac", int'(cal_dac), DMID);
    cal_mode = 2'b01; valid_pct = 100; sat_pct = 100; run(40);
    check("R5 off 01 dac", int'(cal_dac), DMID);
    cal_mode = 2'b11; step_pos = 8'd100; tick_every = 4; run(3);
    @(negedge clk);
    check("R5 preset restart", int'(cal_dac), DMID);
    run(100);

    tag = "R1"; rst_n = 0; run(3);
    @(negedge clk);
    check("R1 reset again", int'(cal_dac), DMID);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule